// File: doc/BRIEF.md
# CCD Vertical Readout Mode Sequencer

This block paces the vertical side of an interline CCD sensor, one line at a time. It counts incoming horizontal sync pulses and issues a vertical sync pulse at the start of each frame. For every line it reports which vertical activity is under way: normal line transfer, charge readout, fast frame shift or fast sweep. It also strobes the readout gate at the lines where photodiode charge is moved into the vertical register. The block has four readout patterns, selected per frame: a full-resolution frame split into two fields, a line-skipping high-rate frame, and two autofocus crops. The autofocus crops are cut out by a fixed frame-shift window followed by a fixed sweep window. Each pattern has its own frame length for each of the two video standards.

A mechanical-shutter exposure is started with a single request pulse. The block then raises the substrate-bias control for a fixed lead time and enables a burst of electronic-shutter pulses. Next it holds off readout for the exposure time and, once the bias control drops, sweeps the vertical register for two full fields. After the sweep it starts a fresh two-field frame, whatever mode is selected. The mode and standard inputs are sampled only at frame starts. A frame-end level marks the last line of every frame for the horizontal timing generator.

Top module: `ccd_vseq`

## Requirements
- R1: While reset is held, vd, rd_gate, frame_end, shut_en and sub_ctrl are 0 and act_mode is 0.
- R2: The number of hd pulses between consecutive vd pulses depends on the active mode and std_sel. With std_sel 0 it is 1772 for mode 0 (two-field), 287 for mode 1 (high-rate), 144 for mode 2 (autofocus 1) and 72 for mode 3 (autofocus 2). With std_sel 1 the same modes give 1770, 343, 172 and 86.
- R3: In mode 0, rd_gate pulses twice per frame: with vd, and at line index half = frame length / 2 (886 or 885). field_b is high from that line to the frame end, so it is high for 886 lines with std_sel 0 and 885 lines with std_sel 1.
- R4: In mode 1, rd_gate pulses once per frame (with vd), and no line has phase 2 (frame shift) or phase 3 (sweep). Phase codes are 0 transfer, 1 readout, 2 frame shift and 3 sweep.
- R5: In mode 2, lines 1 to 10 of the frame have phase 2 and the following 11 lines have phase 3.
- R6: In mode 3, 17 lines have phase 2 followed by 17 lines of phase 3.
- R7: A change of mode_sel in the middle of a frame leaves act_mode unchanged until the next vd, where act_mode takes the new value.
- R8: frame_end is high on exactly one line per frame, the last one, and the hd that ends that line is followed by vd in the next cycle.
- R9: After an expo_req pulse, sub_ctrl is high for 178 hd lines before shut_en rises, and sub_ctrl stays high whenever shut_en is high.
- R10: shut_en stays high for exactly 20 hd pulses, one electronic-shutter pulse per line.
- R11: When sub_ctrl falls, phase is 3 for 1772 lines (two fields at std_sel 0). No rd_gate occurs between the shutter burst and the end of the sweep. The sweep ends with vd plus rd_gate, and the frame that follows is a two-field frame (act_mode 0, 1772 lines, two readout strobes) even when mode_sel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| hd | input | 1 | one-cycle horizontal sync pulse, one per line |
| mode_sel | input | 2 | requested readout pattern 0..3 |
| std_sel | input | 1 | video standard, 0 = 525-line timing, 1 = 625-line timing |
| expo_req | input | 1 | pulse that starts a mechanical-shutter exposure |
| vd | output | 1 | one-cycle vertical sync at frame start |
| rd_gate | output | 1 | one-cycle readout gate strobe |
| frame_end | output | 1 | high during the last line of the frame |
| field_b | output | 1 | second field of a two-field frame |
| phase | output | 2 | vertical activity of the current line |
| act_mode | output | 2 | mode in force for the current frame |
| shut_en | output | 1 | electronic-shutter pulse enable, one pulse per line |
| sub_ctrl | output | 1 | substrate-bias control for mechanical exposure |

## Verification
The hardest behaviour to reach is the end of an exposure. There, a sweep timed by the exposure counter cuts a running frame short and forces a two-field frame. This is visible only after about two thousand lines of lead, shutter burst, exposure and sweep. The bench starts the exposure while high-rate mode is selected, so any two-field readout that follows can only come from the forced frame. It counts hd pulses with sub_ctrl, shut_en and sweep phase in each stage and looks for readout strobes that leak inside the hold window.

// File: rtl/ccd_vseq.sv
module ccd_vseq #(
  parameter int LW = 11,
  parameter int EW = 16,
  parameter int L2F_A = 1772,
  parameter int L2F_B = 1770,
  parameter int LHF_A = 287,
  parameter int LHF_B = 343,
  parameter int LAF1_A = 144,
  parameter int LAF1_B = 172,
  parameter int LAF2_A = 72,
  parameter int LAF2_B = 86,
  parameter int AF1_SHIFT = 10,
  parameter int AF1_SWEEP = 11,
  parameter int AF2_SHIFT = 17,
  parameter int AF2_SWEEP = 17,
  parameter int LEAD_LINES = 178,
  parameter int SHUT_PULSES = 20,
  parameter int EXPO_LINES = 64,
  parameter int SWEEP_FIELDS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hd,
  input  logic [1:0] mode_sel,
  input  logic       std_sel,
  input  logic       expo_req,
  output logic       vd,
  output logic       rd_gate,
  output logic       frame_end,
  output logic       field_b,
  output logic [1:0] phase,
  output logic [1:0] act_mode,
  output logic       shut_en,
  output logic       sub_ctrl
);
  localparam int SWP_A = SWEEP_FIELDS * (L2F_A / 2);
  localparam int SWP_B = SWEEP_FIELDS * (L2F_B / 2);

  typedef enum logic [2:0] {X_IDLE, X_LEAD, X_SHUT, X_EXPO, X_SWP} xs_t;

  xs_t           xs;
  logic [LW-1:0] lc, flen, half, fs_n, sw_n;
  logic [EW-1:0] ec, lim;
  logic          std_q, hold, wrap, restart, new_frame, last_ec;

  always_comb begin
    case (act_mode)
      2'd0:    flen = std_q ? LW'(L2F_B)  : LW'(L2F_A);
      2'd1:    flen = std_q ? LW'(LHF_B)  : LW'(LHF_A);
      2'd2:    flen = std_q ? LW'(LAF1_B) : LW'(LAF1_A);
      default: flen = std_q ? LW'(LAF2_B) : LW'(LAF2_A);
    endcase
  end

  assign half = flen >> 1;
  assign fs_n = (act_mode == 2'd2) ? LW'(AF1_SHIFT) : (act_mode == 2'd3) ? LW'(AF2_SHIFT) : '0;
  assign sw_n = (act_mode == 2'd2) ? LW'(AF1_SWEEP) : (act_mode == 2'd3) ? LW'(AF2_SWEEP) : '0;

  always_comb begin
    case (xs)
      X_LEAD:  lim = EW'(LEAD_LINES);
      X_SHUT:  lim = EW'(SHUT_PULSES);
      X_EXPO:  lim = EW'(EXPO_LINES);
      X_SWP:   lim = std_q ? EW'(SWP_B) : EW'(SWP_A);
      default: lim = '0;
    endcase
  end

  assign last_ec   = hd && (xs != X_IDLE) && (ec == lim - EW'(1));
  assign wrap      = hd && (lc == flen - LW'(1));
  assign restart   = last_ec && (xs == X_SWP);
  assign new_frame = wrap || restart;
  assign hold      = (xs == X_SHUT) || (xs == X_EXPO) || (xs == X_SWP);

  assign sub_ctrl  = (xs == X_LEAD) || (xs == X_SHUT) || (xs == X_EXPO);
  assign shut_en   = (xs == X_SHUT);
  assign frame_end = (lc == flen - LW'(1));
  assign field_b   = (act_mode == 2'd0) && (lc >= half);

  always_comb begin
    if (xs == X_SWP)                                    phase = 2'd3;
    else if (lc == '0 || (act_mode == 2'd0 && lc == half)) phase = 2'd1;
    else if (lc <= fs_n)                                phase = 2'd2;
    else if (lc <= fs_n + sw_n)                         phase = 2'd3;
    else                                                phase = 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc       <= '0;
      act_mode <= 2'd0;
      std_q    <= 1'b0;
      vd       <= 1'b0;
      rd_gate  <= 1'b0;
      xs       <= X_IDLE;
      ec       <= '0;
    end else begin
      vd      <= new_frame;
      rd_gate <= restart || (hd && !hold &&
                 (wrap || (act_mode == 2'd0 && lc + LW'(1) == half)));
      if (new_frame) begin
        lc       <= '0;
        act_mode <= restart ? 2'd0 : mode_sel;
        std_q    <= std_sel;
      end else if (hd) begin
        lc <= lc + LW'(1);
      end
      if (xs == X_IDLE) begin
        if (expo_req) begin
          xs <= X_LEAD;
          ec <= '0;
        end
      end else if (hd) begin
        if (last_ec) begin
          ec <= '0;
          case (xs)
            X_LEAD:  xs <= X_SHUT;
            X_SHUT:  xs <= X_EXPO;
            X_EXPO:  xs <= X_SWP;
            default: xs <= X_IDLE;
          endcase
        end else begin
          ec <= ec + EW'(1);
        end
      end
    end
  end

  // R2
  vd_hd_chk: assert property (@(posedge clk) disable iff (!rst_n) vd |-> $past(hd));
  // R8
  fe_vd_chk: assert property (@(posedge clk) disable iff (!rst_n) (hd && frame_end) |=> vd);
  // R3
  rd_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_gate |-> (phase == 2'd1));
  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !vd |-> $stable(act_mode));
  // R9
  shut_sub_chk: assert property (@(posedge clk) disable iff (!rst_n) shut_en |-> sub_ctrl);
  // R11
  swp_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(sub_ctrl) |-> (phase == 2'd3));
endmodule

// File: tb/ccd_vseq_test.sv
module ccd_vseq_test;
  logic clk = 1'b0, rst_n = 1'b0, hd = 1'b0, std_sel = 1'b0, expo_req = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic vd, rd_gate, frame_end, field_b, shut_en, sub_ctrl;
  logic [1:0] phase, act_mode;
  int total = 0, bad = 0;

  int ln = 0, n_rd = 0, n_fs = 0, n_sw = 0, n_fe = 0, n_fb = 0;
  int l_len = 0, l_rd = 0, l_fs = 0, l_sw = 0, l_fe = 0, l_fb = 0;
  int x_lead = 0, x_shut = 0, x_swp = 0, x_rdbad = 0, x_mode = 9;
  bit seen_shut = 0, restarted = 0;
  event vd_ev;

  ccd_vseq uut (.clk(clk), .rst_n(rst_n), .hd(hd), .mode_sel(mode_sel), .std_sel(std_sel),
    .expo_req(expo_req), .vd(vd), .rd_gate(rd_gate), .frame_end(frame_end), .field_b(field_b),
    .phase(phase), .act_mode(act_mode), .shut_en(shut_en), .sub_ctrl(sub_ctrl));

  always #2 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk); #1 hd = 1'b1;
      @(posedge clk); #1 hd = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (hd && sub_ctrl && !shut_en && !seen_shut) x_lead++;
    if (hd && shut_en) x_shut++;
    if (shut_en) seen_shut = 1;
    if (hd && phase == 2'd3) x_swp++;
    if (vd && rd_gate && seen_shut && x_swp > 0 && !restarted) begin
      restarted = 1;
      x_mode = act_mode;
    end
    if (rd_gate && seen_shut && !restarted) x_rdbad++;
    if (vd) begin
      l_len = ln; l_rd = n_rd; l_fs = n_fs; l_sw = n_sw; l_fe = n_fe; l_fb = n_fb;
      ln = 0; n_rd = 0; n_fs = 0; n_sw = 0; n_fe = 0; n_fb = 0;
    end
    if (rd_gate) n_rd++;
    if (hd) begin
      ln++;
      if (phase == 2'd2) n_fs++;
      if (phase == 2'd3) n_sw++;
      if (frame_end) n_fe++;
      if (field_b) n_fb++;
    end
    if (vd) -> vd_ev;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 vd", vd, 0);
    chk("R1 rd_gate", rd_gate, 0);
    chk("R1 frame_end", frame_end, 0);
    chk("R1 shut_en", shut_en, 0);
    chk("R1 sub_ctrl", sub_ctrl, 0);
    chk("R1 act_mode", act_mode, 0);
  endtask

  task automatic t_frame(input int m, input int s, input int len, input int rd,
                         input int fs, input int sw, input int fb);
    mode_sel = 2'(m);
    std_sel = 1'(s);
    @(vd_ev);
    @(vd_ev);
    chk($sformatf("R2 len m%0d s%0d", m, s), l_len, len);
    chk($sformatf("R7 act_mode m%0d", m), act_mode, m);
    chk($sformatf("R8 frame_end lines m%0d", m), l_fe, 1);
    if (m == 0) begin
      chk($sformatf("R3 strobes s%0d", s), l_rd, rd);
      chk($sformatf("R3 field_b lines s%0d", s), l_fb, fb);
    end else if (m == 1) begin
      chk($sformatf("R4 strobes s%0d", s), l_rd, rd);
      chk($sformatf("R4 shift+sweep s%0d", s), l_fs + l_sw, 0);
    end else if (m == 2) begin
      chk($sformatf("R5 shift s%0d", s), l_fs, fs);
      chk($sformatf("R5 sweep s%0d", s), l_sw, sw);
    end else begin
      chk($sformatf("R6 shift s%0d", s), l_fs, fs);
      chk($sformatf("R6 sweep s%0d", s), l_sw, sw);
    end
  endtask

  task automatic t_modechg;
    mode_sel = 2'd1;
    std_sel = 1'b0;
    @(vd_ev);
    @(vd_ev);
    repeat (40) @(negedge clk);
    mode_sel = 2'd3;
    @(negedge clk);
    chk("R7 held mid-frame", act_mode, 1);
    @(vd_ev);
    chk("R7 taken at vd", act_mode, 3);
    @(vd_ev);
    chk("R7 new frame len", l_len, 72);
  endtask

  task automatic t_expo;
    mode_sel = 2'd1;
    std_sel = 1'b0;
    @(vd_ev);
    @(vd_ev);
    x_lead = 0; x_shut = 0; x_swp = 0; x_rdbad = 0; seen_shut = 0; restarted = 0;
    @(posedge clk); #1 expo_req = 1'b1;
    @(posedge clk); #1 expo_req = 1'b0;
    while (!restarted) @(vd_ev);
    chk("R9 lead lines", x_lead, 178);
    chk("R10 shutter pulses", x_shut, 20);
    chk("R11 sweep lines", x_swp, 1772);
    chk("R11 strobes during hold", x_rdbad, 0);
    chk("R11 forced mode", x_mode, 0);
    chk("R11 sub_ctrl low", sub_ctrl, 0);
    @(vd_ev);
    chk("R11 forced frame len", l_len, 1772);
    chk("R11 forced frame strobes", l_rd, 2);
    chk("R11 mode back to select", act_mode, 1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    t_frame(0, 0, 1772, 2, 0, 0, 886);
    t_frame(0, 1, 1770, 2, 0, 0, 885);
    t_frame(1, 0, 287, 1, 0, 0, 0);
    t_frame(1, 1, 343, 1, 0, 0, 0);
    t_frame(2, 0, 144, 1, 10, 11, 0);
    t_frame(2, 1, 172, 1, 10, 11, 0);
    t_frame(3, 0, 72, 1, 17, 17, 0);
    t_frame(3, 1, 86, 1, 17, 17, 0);
    t_modechg();
    t_expo();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule